// File: doc/BRIEF.md
# UART Channel Command and Flow-Control Unit

This block sits beside one UART transmit channel and interprets the commands a host writes into the channel's command register. The command code is the five-bit field in bits [7:3] of the written byte; the three low bits carry no meaning. Each write produces either a one-cycle action pulse for a neighbouring block (receiver reset, transmitter reset, error-status reset, break-change interrupt reset, address-recognition status reset, clear of all channel registers) or a change to persistent control state (break transmission, RTS level, time-out mode, host Xoff, a queued flow-control character).

The block also decides, at each character boundary, what the transmit shift register loads next. A queued Xon or Xoff character goes out ahead of FIFO data. FIFO data moves only when no host Xoff is in force and no break is being sent. A character already in the shift register always runs to the end of its stop bit, because the block only acts while the shift register reports idle. Baud timing, the FIFO storage and the host bus are outside this block.

Top module: `uart_cmd_flow`

## Requirements
- R1: The code is taken from bits [7:3] of the command byte, and bits [2:0] are ignored. Codes 00010, 00011, 00100, 00101, 11011 and 11110 raise the receiver-reset, transmitter-reset, error-reset, break-change-reset, address-status-reset and channel-clear pulse respectively. The pulse is high during the clock cycle after the edge that sampled the write strobe.
- R2: At most one action pulse is high in any cycle, each pulse lasts exactly one cycle, and no pulse appears without a write.
- R3: Code 00110 sets break_active and 00111 clears it. While break_active is high, shreg_load stays low.
- R4: Code 01000 sets rts_active and 01001 clears it.
- R5: Code 01010 sets timeout_mode and 01100 clears it.
- R6: Code 10000 queues the Xon character (parameter XON_CHAR, default 8'h11), and 10001 queues the Xoff character (XOFF_CHAR, default 8'h13). When shreg_busy is low, a queued character is presented on shreg_data with shreg_load high and fifo_pop low, ahead of any FIFO data. It leaves the queue at that clock edge.
- R7: Code 10111 sets host_xoff. While host_xoff is set, no FIFO character is loaded (fifo_pop and shreg_load stay low with no queued flow character).
- R8: Code 10110 clears host_xoff only when auto_flow_en is low. With auto_flow_en high it has no effect. After the clear, the next FIFO character is loaded at the next boundary.
- R9: Code 11000 removes a queued flow character that has not been loaded. With nothing queued, it changes nothing.
- R10: Code 00011 also clears host_xoff and any queued flow character. Code 11110 clears break_active, rts_active, timeout_mode, host_xoff and the queue.
- R11: Codes without a listed meaning (for example 00000, 00001, 01011, 11001, 11111) raise no pulse and change no state.
- R12: After reset all pulses and all state outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_byte | input | 8 | Written command byte; code in [7:3] |
| auto_flow_en | input | 1 | Automatic transmit flow control enabled |
| fifo_valid | input | 1 | Transmit FIFO holds a character |
| fifo_data | input | DW | Character at the FIFO head |
| shreg_busy | input | 1 | Shift register still sending a character |
| fifo_pop | output | 1 | Remove the FIFO head this cycle |
| shreg_load | output | 1 | Load shreg_data into the shift register this cycle |
| shreg_data | output | DW | Character to load |
| rx_reset_pulse | output | 1 | Receiver reset pulse |
| tx_reset_pulse | output | 1 | Transmitter reset pulse |
| err_reset_pulse | output | 1 | Error-status reset pulse |
| brk_chg_reset_pulse | output | 1 | Break-change interrupt reset pulse |
| addr_stat_reset_pulse | output | 1 | Address-recognition status reset pulse |
| chan_clear_pulse | output | 1 | Clear-all-channel-registers pulse |
| break_active | output | 1 | Break transmission requested |
| rts_active | output | 1 | RTS asserted |
| timeout_mode | output | 1 | Receiver time-out mode on |
| host_xoff | output | 1 | Transmitter halted by host Xoff |
| flow_char_pending | output | 1 | Xon/Xoff character queued |

## Verification
Pulses and state outputs are registered, so they settle one clock edge after the edge that samples cmd_we. The bench raises the strobe at a falling edge, drops it at the next falling edge and reads the outputs there, then confirms one cycle later that the pulse has gone. The load decision (shreg_load, shreg_data, fifo_pop) follows shreg_busy and the held state in the same cycle. It is checked a short delay after the bench changes shreg_busy, and then again after the next edge, once a queued character has left the queue.

// File: rtl/uart_cmd_pkg.sv
// Shared command codes and decoded-action record for the UART command unit.
// Assumes a 5-bit command field; the codes are fixed by the host's view.
package uart_cmd_pkg;

    localparam int CODE_W  = 5;
    localparam int CODE_LSB = 3;

    typedef enum logic [CODE_W-1:0] {
        C_RX_RST    = 5'b00010,
        C_TX_RST    = 5'b00011,
        C_ERR_RST   = 5'b00100,
        C_BRK_RST   = 5'b00101,
        C_BREAK_ON  = 5'b00110,
        C_BREAK_OFF = 5'b00111,
        C_RTS_ON    = 5'b01000,
        C_RTS_OFF   = 5'b01001,
        C_TO_ON     = 5'b01010,
        C_TO_OFF    = 5'b01100,
        C_SEND_XON  = 5'b10000,
        C_SEND_XOFF = 5'b10001,
        C_RESUME    = 5'b10110,
        C_HOST_XOFF = 5'b10111,
        C_CANCEL    = 5'b11000,
        C_ADDR_RST  = 5'b11011,
        C_CHAN_CLR  = 5'b11110
    } cmd_code_e;

    // One bit per recognised command, already qualified by the write strobe.
    typedef struct packed {
        logic rx_rst;
        logic tx_rst;
        logic err_rst;
        logic brk_rst;
        logic addr_rst;
        logic chan_clr;
        logic break_on;
        logic break_off;
        logic rts_on;
        logic rts_off;
        logic to_on;
        logic to_off;
        logic send_xon;
        logic send_xoff;
        logic resume;
        logic host_xoff;
        logic cancel;
    } act_t;

    // Registered one-cycle pulses handed to neighbouring blocks.
    typedef struct packed {
        logic rx_rst;
        logic tx_rst;
        logic err_rst;
        logic brk_rst;
        logic addr_rst;
        logic chan_clr;
    } pulse_t;

endpackage

// File: rtl/uart_cmd_decode.sv
// Command decoder: turns a written code into a one-hot action record and
// registers the externally visible action pulses.
// Assumes at most one write per cycle; unknown codes decode to no action.
module uart_cmd_decode
    import uart_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CODE_W-1:0] code,
    output act_t              act,
    output pulse_t            pulse_q
);

    // Decode the code into at most one action bit, gated by the strobe.
    always_comb begin
        act = '0;
        if (cmd_we) begin
            case (code)
                C_RX_RST:    act.rx_rst    = 1'b1;
                C_TX_RST:    act.tx_rst    = 1'b1;
                C_ERR_RST:   act.err_rst   = 1'b1;
                C_BRK_RST:   act.brk_rst   = 1'b1;
                C_ADDR_RST:  act.addr_rst  = 1'b1;
                C_CHAN_CLR:  act.chan_clr  = 1'b1;
                C_BREAK_ON:  act.break_on  = 1'b1;
                C_BREAK_OFF: act.break_off = 1'b1;
                C_RTS_ON:    act.rts_on    = 1'b1;
                C_RTS_OFF:   act.rts_off   = 1'b1;
                C_TO_ON:     act.to_on     = 1'b1;
                C_TO_OFF:    act.to_off    = 1'b1;
                C_SEND_XON:  act.send_xon  = 1'b1;
                C_SEND_XOFF: act.send_xoff = 1'b1;
                C_RESUME:    act.resume    = 1'b1;
                C_HOST_XOFF: act.host_xoff = 1'b1;
                C_CANCEL:    act.cancel    = 1'b1;
                default:     act = '0;
            endcase
        end
    end

    // Register the pulse subset so each lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else begin
            pulse_q.rx_rst   <= act.rx_rst;
            pulse_q.tx_rst   <= act.tx_rst;
            pulse_q.err_rst  <= act.err_rst;
            pulse_q.brk_rst  <= act.brk_rst;
            pulse_q.addr_rst <= act.addr_rst;
            pulse_q.chan_clr <= act.chan_clr;
        end
    end

    // R2: never more than one pulse at a time.
    a_r2_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_q));

    // R2: a pulse only follows a write.
    a_r2_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we == 1'b0 |=> pulse_q == '0);

    // R1: receiver reset code yields its pulse one cycle later.
    a_r1_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && code == C_RX_RST) |=> pulse_q.rx_rst);

    // R11: reserved codes yield no pulse.
    a_r11_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && (code == 5'b00000 || code == 5'b00001 || code == 5'b11111))
        |=> pulse_q == '0);

endmodule

// File: rtl/uart_cmd_ctrl_state.sv
// Persistent line-control state: break request, RTS level, time-out mode.
// Assumes actions arrive one-hot from the decoder; channel clear wins.
module uart_cmd_ctrl_state
    import uart_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  act_t act,
    output logic break_q,
    output logic rts_q,
    output logic to_q
);

    // Update each set/clear flag from its command pair.
    always_ff @(posedge clk) begin
        if (!rst_n || act.chan_clr) begin
            break_q <= 1'b0;
            rts_q   <= 1'b0;
            to_q    <= 1'b0;
        end else begin
            if (act.break_on)       break_q <= 1'b1;
            else if (act.break_off) break_q <= 1'b0;
            if (act.rts_on)         rts_q   <= 1'b1;
            else if (act.rts_off)   rts_q   <= 1'b0;
            if (act.to_on)          to_q    <= 1'b1;
            else if (act.to_off)    to_q    <= 1'b0;
        end
    end

    // R4: RTS asserts after its command.
    a_r4_rts_set: assert property (@(posedge clk) disable iff (!rst_n)
        act.rts_on |=> rts_q);

    // R5: time-out mode drops after its off command.
    a_r5_to_clear: assert property (@(posedge clk) disable iff (!rst_n)
        act.to_off |=> !to_q);

    // R3: break request holds until an off or clear command.
    a_r3_break_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (break_q && !act.break_off && !act.chan_clr) |=> break_q);

endmodule

// File: rtl/uart_tx_flow_gate.sv
// Transmit flow gate: holds host-Xoff and the queued Xon/Xoff character and
// picks what the shift register loads at each character boundary.
// Assumes shreg_busy stays high until the stop bit of the current character
// is finished, so nothing here can cut a character short.
module uart_tx_flow_gate
    import uart_cmd_pkg::*;
#(
    parameter int             DW        = 8,
    parameter logic [DW-1:0]  XON_CHAR  = 8'h11,
    parameter logic [DW-1:0]  XOFF_CHAR = 8'h13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  act_t          act,
    input  logic          auto_flow_en,
    input  logic          break_on,
    input  logic          fifo_valid,
    input  logic [DW-1:0] fifo_data,
    input  logic          shreg_busy,
    output logic          fifo_pop,
    output logic          shreg_load,
    output logic [DW-1:0] shreg_data,
    output logic          hx_q,
    output logic          pend_q
);

    logic pend_xoff_q;
    logic boundary;
    logic load_flow;
    logic load_fifo;
    logic wipe;

    assign wipe = act.tx_rst | act.chan_clr;

    // Choose the next load: queued flow character first, then FIFO data.
    always_comb begin
        boundary   = !shreg_busy && !break_on;
        load_flow  = boundary && pend_q;
        load_fifo  = boundary && !pend_q && !hx_q && fifo_valid;
        shreg_load = load_flow || load_fifo;
        fifo_pop   = load_fifo;
        shreg_data = load_flow ? (pend_xoff_q ? XOFF_CHAR : XON_CHAR) : fifo_data;
    end

    // Host Xoff flag: set by command, cleared by resume unless automatic mode.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)
            hx_q <= 1'b0;
        else if (act.host_xoff)
            hx_q <= 1'b1;
        else if (act.resume && !auto_flow_en)
            hx_q <= 1'b0;
    end

    // Flow-character queue: a new request wins, then cancel or load empties it.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            pend_q      <= 1'b0;
            pend_xoff_q <= 1'b0;
        end else if (act.send_xon || act.send_xoff) begin
            pend_q      <= 1'b1;
            pend_xoff_q <= act.send_xoff;
        end else if (act.cancel || load_flow) begin
            pend_q      <= 1'b0;
        end
    end

    // R3: nothing is loaded while a break is being sent.
    a_r3_no_load_in_break: assert property (@(posedge clk) disable iff (!rst_n)
        break_on |-> !shreg_load);

    // R7: host Xoff keeps FIFO data in place.
    a_r7_hold_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        hx_q |-> !fifo_pop);

    // R6: a loaded flow character leaves the queue unless re-queued.
    a_r6_served: assert property (@(posedge clk) disable iff (!rst_n)
        (load_flow && !act.send_xon && !act.send_xoff) |=> !pend_q);

    // R8: resume does nothing in automatic flow-control mode.
    a_r8_auto_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (hx_q && act.resume && auto_flow_en) |=> hx_q);

    // R9: cancel empties the queue.
    a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        act.cancel |=> !pend_q);

    // R10: transmitter reset clears halt and queue.
    a_r10_tx_reset: assert property (@(posedge clk) disable iff (!rst_n)
        act.tx_rst |=> (!hx_q && !pend_q));

endmodule

// File: rtl/uart_cmd_flow.sv
// Top of the per-channel command and transmit flow-control unit.
// Decodes host command writes into pulses and control state, and gates the
// transmit FIFO into the shift register. Assumes one command per write.
module uart_cmd_flow
    import uart_cmd_pkg::*;
#(
    parameter int             DW        = 8,
    parameter logic [DW-1:0]  XON_CHAR  = 8'h11,
    parameter logic [DW-1:0]  XOFF_CHAR = 8'h13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [7:0]    cmd_byte,
    input  logic          auto_flow_en,
    input  logic          fifo_valid,
    input  logic [DW-1:0] fifo_data,
    input  logic          shreg_busy,
    output logic          fifo_pop,
    output logic          shreg_load,
    output logic [DW-1:0] shreg_data,
    output logic          rx_reset_pulse,
    output logic          tx_reset_pulse,
    output logic          err_reset_pulse,
    output logic          brk_chg_reset_pulse,
    output logic          addr_stat_reset_pulse,
    output logic          chan_clear_pulse,
    output logic          break_active,
    output logic          rts_active,
    output logic          timeout_mode,
    output logic          host_xoff,
    output logic          flow_char_pending
);

    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

    act_t   act;
    pulse_t pulse_q;
    logic   break_q;

    uart_cmd_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_we  (cmd_we),
        .code    (cmd_byte[CODE_MSB:CODE_LSB]),
        .act     (act),
        .pulse_q (pulse_q)
    );

    uart_cmd_ctrl_state u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .break_q (break_q),
        .rts_q   (rts_active),
        .to_q    (timeout_mode)
    );

    uart_tx_flow_gate #(
        .DW        (DW),
        .XON_CHAR  (XON_CHAR),
        .XOFF_CHAR (XOFF_CHAR)
    ) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .act          (act),
        .auto_flow_en (auto_flow_en),
        .break_on     (break_q),
        .fifo_valid   (fifo_valid),
        .fifo_data    (fifo_data),
        .shreg_busy   (shreg_busy),
        .fifo_pop     (fifo_pop),
        .shreg_load   (shreg_load),
        .shreg_data   (shreg_data),
        .hx_q         (host_xoff),
        .pend_q       (flow_char_pending)
    );

    assign break_active          = break_q;
    assign rx_reset_pulse        = pulse_q.rx_rst;
    assign tx_reset_pulse        = pulse_q.tx_rst;
    assign err_reset_pulse       = pulse_q.err_rst;
    assign brk_chg_reset_pulse   = pulse_q.brk_rst;
    assign addr_stat_reset_pulse = pulse_q.addr_rst;
    assign chan_clear_pulse      = pulse_q.chan_clr;

    // R1: the whole written byte is driven to known values (low bits unused).
    a_r1_byte_known: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |-> !$isunknown(cmd_byte));

endmodule

// File: tb/uart_cmd_flow_test.sv
// Directed bench for the command and flow-control unit.
module uart_cmd_flow_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       auto_flow_en = 1'b0;
    logic       fifo_valid = 1'b0;
    logic [7:0] fifo_data = 8'hA5;
    logic       shreg_busy = 1'b1;
    logic       fifo_pop, shreg_load;
    logic [7:0] shreg_data;
    logic       rx_p, tx_p, err_p, brk_p, addr_p, clr_p;
    logic       break_active, rts_active, timeout_mode, host_xoff, pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uart_cmd_flow uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .auto_flow_en(auto_flow_en), .fifo_valid(fifo_valid),
        .fifo_data(fifo_data), .shreg_busy(shreg_busy),
        .fifo_pop(fifo_pop), .shreg_load(shreg_load), .shreg_data(shreg_data),
        .rx_reset_pulse(rx_p), .tx_reset_pulse(tx_p), .err_reset_pulse(err_p),
        .brk_chg_reset_pulse(brk_p), .addr_stat_reset_pulse(addr_p),
        .chan_clear_pulse(clr_p), .break_active(break_active),
        .rts_active(rts_active), .timeout_mode(timeout_mode),
        .host_xoff(host_xoff), .flow_char_pending(pend)
    );

    function automatic logic [5:0] pulses();
        return {rx_p, tx_p, err_p, brk_p, addr_p, clr_p};
    endfunction

    function automatic logic [4:0] state_vec();
        return {break_active, rts_active, timeout_mode, host_xoff, pend};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Write one code; returns at the falling edge where results are due.
    task automatic send(input logic [4:0] code);
        @(negedge clk);
        cmd_we   = 1'b1;
        cmd_byte = {code, 3'b101};
        @(negedge clk);
        cmd_we   = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 pulses", {26'd0, pulses()}, 0);
        chk("R12 state", {27'd0, state_vec()}, 0);
        chk("R12 load", {31'd0, shreg_load}, 0);
    endtask

    task automatic t_pulses();
        logic [4:0] codes [6] = '{5'b00010, 5'b00011, 5'b00100, 5'b00101, 5'b11011, 5'b11110};
        for (int i = 0; i < 6; i++) begin
            send(codes[i]);
            chk("R1 pulse", {26'd0, pulses()}, 32'(6'b100000 >> i));
            @(negedge clk);
            chk("R2 one cycle", {26'd0, pulses()}, 0);
        end
    endtask

    task automatic t_reserved();
        logic [4:0] codes [5] = '{5'b00000, 5'b00001, 5'b01011, 5'b11001, 5'b11111};
        send(5'b01000);
        for (int i = 0; i < 5; i++) begin
            send(codes[i]);
            chk("R11 no pulse", {26'd0, pulses()}, 0);
            chk("R11 no state", {27'd0, state_vec()}, 32'b01000);
        end
        send(5'b01001);
    endtask

    task automatic t_break();
        send(5'b00110);
        chk("R3 break on", {31'd0, break_active}, 1);
        fifo_valid = 1'b1;
        shreg_busy = 1'b0;
        #1;
        chk("R3 no load in break", {31'd0, shreg_load}, 0);
        shreg_busy = 1'b1;
        send(5'b00111);
        chk("R3 break off", {31'd0, break_active}, 0);
        shreg_busy = 1'b0;
        #1;
        chk("R3 load after break", {31'd0, shreg_load}, 1);
        shreg_busy = 1'b1;
    endtask

    task automatic t_rts_to();
        send(5'b01000);
        chk("R4 rts on", {31'd0, rts_active}, 1);
        send(5'b01001);
        chk("R4 rts off", {31'd0, rts_active}, 0);
        send(5'b01010);
        chk("R5 timeout on", {31'd0, timeout_mode}, 1);
        send(5'b01100);
        chk("R5 timeout off", {31'd0, timeout_mode}, 0);
    endtask

    task automatic t_flow_char();
        send(5'b10000);
        chk("R6 xon queued", {31'd0, pend}, 1);
        shreg_busy = 1'b0;
        #1;
        chk("R6 xon first", {23'd0, shreg_load, shreg_data}, 32'h111);
        chk("R6 fifo held", {31'd0, fifo_pop}, 0);
        @(negedge clk);
        chk("R6 queue empty", {31'd0, pend}, 0);
        chk("R6 fifo next", {22'd0, fifo_pop, shreg_load, shreg_data}, 32'h3A5);
        shreg_busy = 1'b1;
        send(5'b10001);
        shreg_busy = 1'b0;
        #1;
        chk("R6 xoff char", {23'd0, shreg_load, shreg_data}, 32'h113);
        @(negedge clk);
        shreg_busy = 1'b1;
    endtask

    task automatic t_host_xoff();
        send(5'b10111);
        chk("R7 host xoff set", {31'd0, host_xoff}, 1);
        shreg_busy = 1'b0;
        #1;
        chk("R7 fifo held", {30'd0, fifo_pop, shreg_load}, 0);
        shreg_busy = 1'b1;
        auto_flow_en = 1'b1;
        send(5'b10110);
        chk("R8 resume ignored in auto", {31'd0, host_xoff}, 1);
        auto_flow_en = 1'b0;
        send(5'b10110);
        chk("R8 resume clears", {31'd0, host_xoff}, 0);
        shreg_busy = 1'b0;
        #1;
        chk("R8 fifo resumes", {22'd0, fifo_pop, shreg_load, shreg_data}, 32'h3A5);
        shreg_busy = 1'b1;
    endtask

    task automatic t_cancel();
        send(5'b10000);
        send(5'b11000);
        chk("R9 cancel empties", {31'd0, pend}, 0);
        shreg_busy = 1'b0;
        #1;
        chk("R9 fifo not xon", {23'd0, shreg_load, shreg_data}, 32'h1A5);
        shreg_busy = 1'b1;
        send(5'b11000);
        chk("R9 cancel idle", {27'd0, state_vec()}, 0);
    endtask

    task automatic t_wipe();
        send(5'b10111);
        send(5'b10001);
        chk("R10 setup", {30'd0, host_xoff, pend}, 3);
        send(5'b00011);
        chk("R10 tx reset clears", {30'd0, host_xoff, pend}, 0);
        send(5'b01000);
        send(5'b01010);
        send(5'b00110);
        send(5'b10111);
        send(5'b10000);
        chk("R10 all set", {27'd0, state_vec()}, 32'h1F);
        send(5'b11110);
        chk("R10 clear all", {27'd0, state_vec()}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pulses();
        t_reserved();
        t_break();
        t_rts_to();
        t_flow_char();
        t_host_xoff();
        t_cancel();
        t_wipe();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule